// File: doc/BRIEF.md
# Resolver Converter Bring-Up Sequencer

This block is a host-side controller that brings a resolver-to-digital converter out of power-up into a working configuration. It talks to the converter through a byte-wide serial master, which is abstracted here as a request/acknowledge handshake. It drives the two resolution-select pins and the two mode pins of the converter directly. On a start pulse it checks the requested input clock and excitation frequencies against their allowed ranges. It then writes the control register with the chosen resolution and reads that register back to confirm the write. Next it programs the excitation frequency word and issues a soft reset.

The excitation word is the excitation frequency times 2^15 divided by the converter clock frequency. A restoring divider computes it at one quotient bit per clock. The divider runs at the same time as the control-register transfers, so its latency is mostly hidden. At the end the block raises a one-cycle done pulse and presents a two-bit result code. That code stays valid until the next accepted start.

Top module: `resolver_init_seq`

## Requirements
- R1: A start with the clock input outside 6,144,000..10,240,000 Hz or the excitation outside 2,000..20,000 Hz finishes at once with result code 1 (argument error) and issues no byte transfer.
- R2: The control data byte is 0x7C OR the resolution code, where codes 0..3 stand for 10, 12, 14 and 16 bits. Pin res0 carries bit 1 of the code and pin res1 carries bit 0, from the accepted start until the next accepted start.
- R3: A complete run sends, in order, the bytes 0x92, control data, 0x92, 0xFF, 0x91, frequency word, 0xF0, 0x00, and then ends with result code 0.
- R4: The byte received during the fourth transfer (the second byte of the read) is the control readback. If its bit 7 is set, the run ends with result code 3 (I/O error) after that transfer, and nothing more is sent.
- R5: The frequency word is floor(excitation × 32768 / clock), truncated to 8 bits.
- R6: A frequency word below 0x04 or above 0x50 ends the run with result code 2 after the readback, and the word is never sent. The bounds 0x04 and 0x50 themselves are accepted.
- R7: spi_req stays high with spi_tx unchanged until a cycle with spi_ack high. After that it drops for at least one cycle before the next byte is requested.
- R8: The mode pins read 2'b10 (configuration) while a run is in progress, and in particular during every transfer. They read 2'b00 when idle.
- R9: done is a single-cycle pulse at the end of every run. busy is low in that cycle. err_code holds its value until the next accepted start.
- R10: A start pulse while busy is ignored. The byte stream, the pins and the result code of the run in progress are unchanged.
- R11: After reset, busy, done, spi_req, err_code, the mode pins and the resolution pins are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a bring-up run |
| res_code | input | 2 | Resolution code (0..3 for 10/12/14/16 bits) |
| fclkin_hz | input | 24 | Converter clock frequency in Hz |
| fexcit_hz | input | 16 | Excitation frequency in Hz |
| spi_req | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Transfer complete, one cycle |
| spi_rx | input | 8 | Byte received in the completed transfer |
| mode_pins | output | 2 | Converter mode pins {a0, a1} |
| res0 | output | 1 | Resolution pin, code MSB |
| res1 | output | 1 | Resolution pin, code LSB |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, one-cycle pulse |
| err_code | output | 2 | 0 ok, 1 argument, 2 word range, 3 I/O |

## Verification
The hardest case to reach is a frequency word that is legal at the input ranges but falls outside the word window. With the clock and excitation both inside their limits, the word can only leave the window on its upper side. The stimulus therefore uses the lowest clock with an excitation just above 15,000 Hz, and 15,000 Hz exactly to land on the 0x50 bound. A serial responder model with varying acknowledge latency supplies the readback. It can be told to set bit 7 so that the I/O-error exit is reached. A second start is also injected in the middle of a run.

// File: rtl/resolver_init_seq.sv
module resolver_init_seq #(
  parameter int CLK_W    = 24,
  parameter int EXC_W    = 16,
  parameter int CLK_MIN  = 6144000,
  parameter int CLK_MAX  = 10240000,
  parameter int EXC_MIN  = 2000,
  parameter int EXC_MAX  = 20000,
  parameter int WORD_MIN = 4,
  parameter int WORD_MAX = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       res_code,
  input  logic [CLK_W-1:0] fclkin_hz,
  input  logic [EXC_W-1:0] fexcit_hz,
  output logic             spi_req,
  output logic [7:0]       spi_tx,
  input  logic             spi_ack,
  input  logic [7:0]       spi_rx,
  output logic [1:0]       mode_pins,
  output logic             res0,
  output logic             res1,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err_code
);
  localparam int NW = EXC_W + 15;
  localparam int CW = $clog2(NW + 1);
  localparam logic [CW-1:0] NW_C = CW'(NW);
  localparam logic [1:0] E_OK = 2'd0, E_ARG = 2'd1, E_WORD = 2'd2, E_IO = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_NEXT} st_t;
  st_t st;

  logic [2:0]       step;
  logic [1:0]       code_q;
  logic [7:0]       rb;
  logic [NW-1:0]    dvd;
  logic [CLK_W-1:0] dvs;
  logic [CLK_W:0]   rem, nrem;
  logic [CW-1:0]    div_cnt;
  logic             ge, args_ok, word_ok;
  logic [7:0]       word;

  assign busy      = (st != S_IDLE);
  assign mode_pins = busy ? 2'b10 : 2'b00;
  assign res0      = code_q[1];
  assign res1      = code_q[0];
  assign word      = dvd[7:0];
  assign word_ok   = (word >= 8'(WORD_MIN)) && (word <= 8'(WORD_MAX));
  assign args_ok   = (fclkin_hz >= CLK_W'(CLK_MIN)) && (fclkin_hz <= CLK_W'(CLK_MAX)) &&
                     (fexcit_hz >= EXC_W'(EXC_MIN)) && (fexcit_hz <= EXC_W'(EXC_MAX));

  always_comb begin
    nrem = {rem[CLK_W-1:0], dvd[NW-1]};
    ge   = (nrem >= {1'b0, dvs});
  end

  always_comb begin
    case (step)
      3'd0:    spi_tx = 8'h92;
      3'd1:    spi_tx = {6'b011111, code_q};
      3'd2:    spi_tx = 8'h92;
      3'd3:    spi_tx = 8'hFF;
      3'd4:    spi_tx = 8'h91;
      3'd5:    spi_tx = word;
      3'd6:    spi_tx = 8'hF0;
      default: spi_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      step     <= '0;
      code_q   <= '0;
      rb       <= '0;
      dvd      <= '0;
      dvs      <= '0;
      rem      <= '0;
      div_cnt  <= '0;
      spi_req  <= 1'b0;
      done     <= 1'b0;
      err_code <= E_OK;
    end else begin
      done <= 1'b0;
      if (div_cnt != '0) begin
        rem     <= ge ? nrem - {1'b0, dvs} : nrem;
        dvd     <= {dvd[NW-2:0], ge};
        div_cnt <= div_cnt - 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          if (!args_ok) begin
            done     <= 1'b1;
            err_code <= E_ARG;
          end else begin
            err_code <= E_OK;
            code_q   <= res_code;
            dvd      <= {fexcit_hz, 15'b0};
            dvs      <= fclkin_hz;
            rem      <= '0;
            div_cnt  <= NW_C;
            step     <= '0;
            spi_req  <= 1'b1;
            st       <= S_XFER;
          end
        end
        S_XFER: if (spi_ack) begin
          spi_req <= 1'b0;
          if (step == 3'd3) rb <= spi_rx;
          st <= S_NEXT;
        end
        default: begin
          if (step == 3'd3 && rb[7]) begin
            done <= 1'b1; err_code <= E_IO; st <= S_IDLE;
          end else if (step == 3'd3 && div_cnt != '0) begin
            st <= S_NEXT;
          end else if (step == 3'd3 && !word_ok) begin
            done <= 1'b1; err_code <= E_WORD; st <= S_IDLE;
          end else if (step == 3'd7) begin
            done <= 1'b1; err_code <= E_OK; st <= S_IDLE;
          end else begin
            step    <= step + 1'b1;
            spi_req <= 1'b1;
            st      <= S_XFER;
          end
        end
      endcase
    end
  end

  // R8
  cfg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> mode_pins == 2'b10);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));
  // R7
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && spi_ack) |=> !spi_req);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));
  // R10
  pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({res0, res1}));
  // R6
  word_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && step == 3'd5) |-> (div_cnt == '0 && word_ok));
endmodule

// File: tb/resolver_init_seq_tb.sv
module resolver_init_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [1:0]  res_code = 0;
  logic [23:0] fclkin_hz = 0;
  logic [15:0] fexcit_hz = 0;
  logic        spi_req, spi_ack = 0;
  logic [7:0]  spi_tx, spi_rx = 0;
  logic [1:0]  mode_pins, err_code;
  logic        res0, res1, busy, done;

  int tests = 0, fails = 0;
  logic [7:0] expq[$];
  int  k = 0;
  bit  bad_rb = 0;
  logic [7:0] rbv = 0;
  int  lat = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  resolver_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .res_code(res_code),
    .fclkin_hz(fclkin_hz), .fexcit_hz(fexcit_hz),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
    .mode_pins(mode_pins), .res0(res0), .res1(res1),
    .busy(busy), .done(done), .err_code(err_code));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (spi_req) begin
        automatic logic [7:0] first = spi_tx;
        automatic logic [7:0] e;
        repeat (lat) @(negedge clk);
        check("R7", spi_tx, first);
        check("R8", mode_pins, 2'b10);
        if (expq.size() == 0) begin
          check(k == 1 ? "R2" : (k == 5 ? "R5" : "R3"), spi_tx, 32'hDEAD);
        end else begin
          e = expq.pop_front();
          check(k == 1 ? "R2" : (k == 5 ? "R5" : "R3"), spi_tx, e);
        end
        if (k == 1) rbv = bad_rb ? (spi_tx | 8'h80) : spi_tx;
        spi_rx  = (k == 3) ? rbv : 8'h00;
        spi_ack = 1;
        @(negedge clk);
        spi_ack = 0;
        check("R7", spi_req, 0);
        k++;
        lat = (lat % 4) + 1;
      end
    end
  end

  task automatic run(input logic [1:0] code, input int fclk, input int fex,
                     input bit bad, input bit poke_busy);
    logic [1:0] exp_err;
    longint w;
    int n;
    bad_rb = bad;
    k = 0;
    expq.delete();
    if (fclk < 6144000 || fclk > 10240000 || fex < 2000 || fex > 20000) exp_err = 2'd1;
    else begin
      expq.push_back(8'h92); expq.push_back(8'h7C | code);
      expq.push_back(8'h92); expq.push_back(8'hFF);
      w = (longint'(fex) * 32768) / fclk;
      w = w & 8'hFF;
      if (bad) exp_err = 2'd3;
      else if (w < 4 || w > 80) exp_err = 2'd2;
      else begin
        expq.push_back(8'h91); expq.push_back(w[7:0]);
        expq.push_back(8'hF0); expq.push_back(8'h00);
        exp_err = 2'd0;
      end
    end
    @(negedge clk);
    res_code = code; fclkin_hz = fclk[23:0]; fexcit_hz = fex[15:0]; start = 1;
    @(negedge clk);
    start = 0;
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      check("R10", busy, 1);
      res_code = ~code; fclkin_hz = 24'd1; fexcit_hz = 16'd1; start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    check("R9", done, 1);
    check("R9", busy, 0);
    check(exp_err == 1 ? "R1" : (exp_err == 3 ? "R4" : (exp_err == 2 ? "R6" : "R3")),
          err_code, exp_err);
    check(poke_busy ? "R10" : "R3", expq.size(), 0);
    if (exp_err != 2'd1) check("R2", {res0, res1}, code);
    @(negedge clk);
    check("R9", done, 0);
    check("R9", err_code, exp_err);
    check("R8", mode_pins, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    check("R11", {busy, done, spi_req, err_code, mode_pins, res0, res1}, 0);
    rst_n = 1;
    run(2'd1, 8192000, 10000, 0, 0);   // R3 defaults, word 0x28
    run(2'd3, 6144000, 20000, 0, 0);   // R5 word 106 -> over range, R6
    run(2'd0, 10240000, 2000, 0, 0);   // R5 word 6
    run(2'd2, 6144000, 15000, 0, 0);   // R6 upper bound 0x50 accepted
    run(2'd2, 6144000, 15200, 0, 0);   // R6 word 81 rejected
    run(2'd3, 7000000, 3000, 0, 0);    // R5 word 14
    run(2'd1, 6143999, 10000, 0, 0);   // R1
    run(2'd1, 8192000, 20001, 0, 0);   // R1
    run(2'd1, 8192000, 1999, 0, 0);    // R1
    run(2'd2, 8192000, 10000, 1, 0);   // R4 readback bit 7
    run(2'd0, 9000000, 12000, 0, 1);   // R10 start while busy
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule